// File: doc/BRIEF.md
# Serial receiver with ninth-bit capture

This block is the receive half of an asynchronous serial port. It watches a single serial input line and recovers characters framed by one low start bit, eight or nine data bits sent least significant bit first, and one high stop bit. A per-cycle enable pulse running at sixteen times the bit rate paces all timing. A start bit is found on a falling edge and confirmed at its centre. Each bit is then decided by a two-of-three vote over the three samples around the middle of the bit.

Nothing reaches the read side until the stop bit has been judged. At that point the low eight data bits land in a read-only holding register and a full flag is raised. An interrupt request follows the full flag while the interrupt enable is high. A separate status bit carries the ninth data bit in 9-bit mode. In 8-bit mode it repeats data bit 7, so software can test that bit the same way in both modes. The full flag is cleared by reading the status with the flag set and then reading the data register. A low stop bit still delivers the data but marks a framing error.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, rx_full, rx_irq, frame_err and ninth_bit are 0 and rx_data is 0x00.
- R2: With nine_bit_mode low, a frame of a low start bit, eight data bits least significant first and a stop bit delivers the eight bits on rx_data and sets rx_full.
- R3: With nine_bit_mode high, a frame carries nine data bits. The low eight appear on rx_data and the ninth (bit 8) appears on ninth_bit.
- R4: With nine_bit_mode low, ninth_bit equals data bit 7 of the delivered character.
- R5: rx_data and ninth_bit keep their previous values until the stop bit of the incoming character has been sampled.
- R6: Each bit takes the majority of samples 7, 8 and 9 of its 16 sample periods, so a glitch lasting one sample period does not change the received value.
- R7: A falling edge whose line is high again at the start bit's centre vote is discarded. No character is delivered and rx_full does not change.
- R8: A stop bit voted low sets frame_err and the data is still delivered. A character with a high stop bit leaves frame_err at 0.
- R9: rx_full clears only on a data_rd pulse that follows a stat_rd pulse made while rx_full was 1. A data_rd pulse without that prior status read leaves rx_full at 1.
- R10: rx_irq is 1 exactly when rx_full is 1 and rx_irq_en is 1.
- R11: A new character delivered while rx_full is still 1 replaces rx_data and keeps rx_full at 1.
- R12: All bit timing advances only on os_tick pulses, so a slower tick rate stretches the bit time proportionally and still receives correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| nine_bit_mode | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rx_irq_en | input | 1 | Receive interrupt enable |
| stat_rd | input | 1 | One-cycle pulse: status read |
| data_rd | input | 1 | One-cycle pulse: data register read |
| rx_data | output | 8 | Received data (low eight bits) |
| ninth_bit | output | 1 | Bit 8 in 9-bit mode, copy of bit 7 in 8-bit mode |
| rx_full | output | 1 | Receive holding register full |
| frame_err | output | 1 | Last delivered character had a low stop bit |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The properties assume that os_tick, stat_rd and data_rd are single-cycle pulses. They also assume that nine_bit_mode does not change while a character is being received. The rxd line may change at any time, because it passes through a synchronizer. The stimulus changes the mode and the tick divider only between frames, with the line idle. It drives every strobe for exactly one clock, away from the sampling edge. The glitch and false-start cases are kept to a single sample period and to less than half a bit.

// File: rtl/rx_pkg.sv
// Shared types for the serial receiver.
// Assumes: nothing beyond the standard language.
package rx_pkg;
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RUN  = 1'b1
    } rx_state_t;
endpackage

// File: rtl/rx_line_sync.sv
// Multi-stage synchronizer for the asynchronous serial line.
// Assumes: STAGES >= 2, and the line idles high (so stages reset to 1).
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_engine.sv
// Frame engine: detects the start edge, counts sample periods and votes
// each bit from the three samples around mid-bit. It also assembles the
// data bits in a shift register and pulses char_done when the stop bit
// is decided.
// Assumes: os_tick is a one-cycle pulse at OS_RATE times the bit rate, and
// long_mode is steady for the duration of a character.
module rx_bit_engine
    import rx_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DATA_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              line,
    input  logic              long_mode,
    output logic              char_done,
    output logic              stop_ok,
    output logic [DATA_W-1:0] shreg
);
    localparam int PH_W   = $clog2(OS_RATE);
    localparam int SLOT_W = $clog2(DATA_W + 2);
    localparam int MID    = OS_RATE / 2;
    localparam logic [PH_W-1:0] PH_A    = PH_W'(MID - 1);
    localparam logic [PH_W-1:0] PH_B    = PH_W'(MID);
    localparam logic [PH_W-1:0] PH_C    = PH_W'(MID + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OS_RATE - 1);

    rx_state_t         state;
    logic [PH_W-1:0]   phase;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] stop_slot;
    logic              v_a, v_b, seen_high, vote, decide;

    // Majority vote and decision strobe for the current bit.
    always_comb begin
        vote      = (v_a & v_b) | (v_a & line) | (v_b & line);
        decide    = os_tick && (state == RX_RUN) && (phase == PH_C);
        stop_slot = long_mode ? SLOT_W'(DATA_W + 1) : SLOT_W'(DATA_W);
        char_done = decide && (slot == stop_slot);
        stop_ok   = vote;
    end

    // Frame sequencing: start detection, sample capture and bit placement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            phase     <= '0;
            slot      <= '0;
            v_a       <= 1'b0;
            v_b       <= 1'b0;
            seen_high <= 1'b0;
            shreg     <= '0;
        end else if (os_tick) begin
            if (state == RX_IDLE) begin
                seen_high <= line;
                if (seen_high && !line) begin
                    state <= RX_RUN;
                    phase <= PH_W'(1);
                    slot  <= '0;
                end
            end else begin
                phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
                if (phase == PH_A) v_a <= line;
                if (phase == PH_B) v_b <= line;
                if (decide) begin
                    if (slot == '0) begin
                        if (vote) begin
                            state     <= RX_IDLE;
                            seen_high <= 1'b1;
                        end else begin
                            slot <= SLOT_W'(1);
                        end
                    end else if (slot == stop_slot) begin
                        state     <= RX_IDLE;
                        seen_high <= vote;
                    end else begin
                        for (int i = 0; i < DATA_W; i++) begin
                            if (slot == SLOT_W'(i + 1)) shreg[i] <= vote;
                        end
                        slot <= slot + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rx_hold_buffer.sv
// Read-side holding register: takes the assembled character on char_done,
// selects the ninth-bit status source by mode, and keeps the full flag
// with its status-then-data clearing handshake.
// Assumes: stat_rd and data_rd are one-cycle pulses.
module rx_hold_buffer #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              stop_ok,
    input  logic              long_mode,
    input  logic [DATA_W-1:0] shreg,
    input  logic              stat_rd,
    input  logic              data_rd,
    output logic [DATA_W-2:0] rx_data,
    output logic              ninth_bit,
    output logic              rx_full,
    output logic              frame_err
);
    logic armed;

    // Load a finished character, or step the flag-clearing handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data   <= '0;
            ninth_bit <= 1'b0;
            rx_full   <= 1'b0;
            frame_err <= 1'b0;
            armed     <= 1'b0;
        end else if (load) begin
            rx_data   <= shreg[DATA_W-2:0];
            ninth_bit <= long_mode ? shreg[DATA_W-1] : shreg[DATA_W-2];
            rx_full   <= 1'b1;
            frame_err <= !stop_ok;
            armed     <= 1'b0;
        end else if (data_rd && armed) begin
            rx_full <= 1'b0;
            armed   <= 1'b0;
        end else if (stat_rd && rx_full) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/serial_rx_core.sv
// Top of the serial receiver: synchronizer, frame engine and holding
// register, plus the gated receive interrupt request.
// Assumes: os_tick at 16x the bit rate; mode steady within a character.
module serial_rx_core #(
    parameter int OS_RATE     = 16,
    parameter int DATA_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              nine_bit_mode,
    input  logic              rx_irq_en,
    input  logic              stat_rd,
    input  logic              data_rd,
    output logic [DATA_W-2:0] rx_data,
    output logic              ninth_bit,
    output logic              rx_full,
    output logic              frame_err,
    output logic              rx_irq
);
    logic              line_s;
    logic              char_done;
    logic              stop_ok;
    logic [DATA_W-1:0] shreg;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    rx_bit_engine #(.OS_RATE(OS_RATE), .DATA_W(DATA_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .line     (line_s),
        .long_mode(nine_bit_mode),
        .char_done(char_done),
        .stop_ok  (stop_ok),
        .shreg    (shreg)
    );

    rx_hold_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (char_done),
        .stop_ok  (stop_ok),
        .long_mode(nine_bit_mode),
        .shreg    (shreg),
        .stat_rd  (stat_rd),
        .data_rd  (data_rd),
        .rx_data  (rx_data),
        .ninth_bit(ninth_bit),
        .rx_full  (rx_full),
        .frame_err(frame_err)
    );

    // Interrupt request follows the full flag under the enable.
    assign rx_irq = rx_full & rx_irq_en;
endmodule

// File: rtl/serial_rx_checks.sv
// Property checker for serial_rx_core, attached by bind.
// Assumes: strobes are single-cycle and mode is steady within a character.
module serial_rx_checks #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_irq_en,
    input logic              long_mode,
    input logic              data_rd,
    input logic              load,
    input logic              rx_full,
    input logic              rx_irq,
    input logic              ninth_bit,
    input logic [DATA_W-2:0] rx_data
);
    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq_en |-> !rx_irq);

    assert_irq_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_full) && rx_irq_en) |-> rx_irq);

    assert_hold_until_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(rx_data) && $stable(ninth_bit)));

    assert_full_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> rx_full);

    assert_full_needs_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !data_rd) |=> rx_full);

    assert_bit7_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !long_mode) |=> (ninth_bit == rx_data[DATA_W-2]));
endmodule

bind serial_rx_core serial_rx_checks #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_irq_en(rx_irq_en),
    .long_mode(nine_bit_mode),
    .data_rd  (data_rd),
    .load     (char_done),
    .rx_full  (rx_full),
    .rx_irq   (rx_irq),
    .ninth_bit(ninth_bit),
    .rx_data  (rx_data)
);

// File: tb/serial_rx_core_test.sv
`timescale 1ns/1ps
module serial_rx_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       nine_bit_mode = 1'b0;
    logic       rx_irq_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic       data_rd = 1'b0;
    logic [7:0] rx_data;
    logic       ninth_bit, rx_full, frame_err, rx_irq;

    int checks = 0;
    int fails  = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    serial_rx_core uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .nine_bit_mode(nine_bit_mode), .rx_irq_en(rx_irq_en),
        .stat_rd(stat_rd), .data_rd(data_rd), .rx_data(rx_data),
        .ninth_bit(ninth_bit), .rx_full(rx_full), .frame_err(frame_err),
        .rx_irq(rx_irq)
    );

    // Tick generator: one pulse every tick_div clocks.
    always @(negedge clk) begin
        os_tick <= (tick_cnt == 0);
        tick_cnt <= (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
    end

    // Behavioural reference model, updated on each rising edge.
    int m_s1, m_s2, m_run, m_phase, m_slot, m_va, m_vb, m_seen;
    int m_bits[9];
    int m_full, m_data, m_ninth, m_ferr, m_armed;
    always @(posedge clk) begin
        int vote, nbits, load, ok;
        load = 0; ok = 0;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_run = 0; m_phase = 0; m_slot = 0;
            m_va = 0; m_vb = 0; m_seen = 0;
            foreach (m_bits[i]) m_bits[i] = 0;
            m_full = 0; m_data = 0; m_ninth = 0; m_ferr = 0; m_armed = 0;
        end else begin
            nbits = nine_bit_mode ? 9 : 8;
            if (os_tick) begin
                if (m_run == 0) begin
                    if (m_seen == 1 && m_s2 == 0) begin
                        m_run = 1; m_phase = 1; m_slot = 0;
                    end
                    m_seen = m_s2;
                end else begin
                    vote = (m_va + m_vb + m_s2) >= 2;
                    if (m_phase == 7) m_va = m_s2;
                    if (m_phase == 8) m_vb = m_s2;
                    if (m_phase == 9) begin
                        if (m_slot == 0) begin
                            if (vote) begin m_run = 0; m_seen = 1; end
                            else m_slot = 1;
                        end else if (m_slot == nbits + 1) begin
                            load = 1; ok = vote; m_run = 0; m_seen = vote;
                        end else begin
                            m_bits[m_slot-1] = vote;
                            m_slot++;
                        end
                    end
                    m_phase = (m_phase + 1) % 16;
                end
            end
            if (load) begin
                m_data = 0;
                for (int i = 0; i < 8; i++) m_data += m_bits[i] << i;
                m_ninth = nine_bit_mode ? m_bits[8] : m_bits[7];
                m_full = 1; m_ferr = !ok; m_armed = 0;
            end else if (data_rd && m_armed) begin
                m_full = 0; m_armed = 0;
            end else if (stat_rd && m_full) begin
                m_armed = 1;
            end
            m_s2 = m_s1; m_s1 = rxd;
        end
    end

    // Compare the model with the outputs on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rx_data != m_data[7:0] || rx_full != m_full[0] || ninth_bit != m_ninth[0]
                || frame_err != m_ferr[0] || rx_irq != (m_full[0] & rx_irq_en)) begin
                fails++;
                $display("FAIL model R2 t=%0t got data=%h full=%b n=%b fe=%b irq=%b exp data=%h full=%0d n=%0d fe=%0d",
                         $time, rx_data, rx_full, ninth_bit, frame_err, rx_irq,
                         m_data, m_full, m_ninth, m_ferr);
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_ticks(int n);
        repeat (n * tick_div) @(negedge clk);
    endtask

    // Drive one frame; glitch_sym selects a symbol (0 = start) to glitch.
    task automatic send_char(int value, int nine, int stop_val, int glitch_sym);
        int nbits = nine ? 9 : 8;
        for (int s = 0; s < nbits + 2; s++) begin
            logic b;
            if (s == 0) b = 1'b0;
            else if (s == nbits + 1) b = stop_val[0];
            else b = value[s-1];
            rxd = b;
            if (s == glitch_sym) begin
                hold_ticks(8);
                rxd = ~b;
                hold_ticks(1);
                rxd = b;
                hold_ticks(7);
            end else begin
                hold_ticks(16);
            end
        end
        rxd = 1'b1;
        hold_ticks(24);
    endtask

    task automatic pulse_stat();
        @(negedge clk); stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic pulse_data();
        @(negedge clk); data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic clear_full();
        pulse_stat(); pulse_data(); @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rx_full", rx_full, 0);
        check("R1 rx_data", rx_data, 0);
        check("R1 ninth_bit", ninth_bit, 0);
        check("R1 frame_err", frame_err, 0);
        check("R1 rx_irq", rx_irq, 0);
        hold_ticks(40);

        // R2 / R4: 8-bit character with bit 7 set
        nine_bit_mode = 1'b0;
        send_char(8'hA5, 0, 1, -1);
        check("R2 rx_data", rx_data, 8'hA5);
        check("R2 rx_full", rx_full, 1);
        check("R4 ninth mirrors bit7=1", ninth_bit, 1);
        check("R8 good stop frame_err", frame_err, 0);

        // R9: data read alone is ignored; status then data clears
        pulse_data(); @(negedge clk);
        check("R9 data read alone keeps full", rx_full, 1);
        clear_full();
        check("R9 status+data clears full", rx_full, 0);

        // R4: bit 7 clear
        send_char(8'h35, 0, 1, -1);
        check("R4 rx_data", rx_data, 8'h35);
        check("R4 ninth mirrors bit7=0", ninth_bit, 0);
        clear_full();

        // R3: 9-bit mode
        nine_bit_mode = 1'b1;
        hold_ticks(4);
        send_char(9'h13C, 1, 1, -1);
        check("R3 rx_data low byte", rx_data, 8'h3C);
        check("R3 ninth bit set", ninth_bit, 1);
        clear_full();
        send_char(9'h0C3, 1, 1, -1);
        check("R3 rx_data low byte", rx_data, 8'hC3);
        check("R3 ninth bit clear", ninth_bit, 0);

        // R10: interrupt gating while full
        rx_irq_en = 1'b1; @(negedge clk);
        check("R10 irq with enable", rx_irq, 1);
        rx_irq_en = 1'b0; @(negedge clk);
        check("R10 irq masked", rx_irq, 0);
        rx_irq_en = 1'b1;
        clear_full();
        check("R10 irq after clear", rx_irq, 0);

        // R8: framing error still delivers data
        nine_bit_mode = 1'b0;
        hold_ticks(4);
        send_char(8'h5A, 0, 0, -1);
        check("R8 data despite bad stop", rx_data, 8'h5A);
        check("R8 frame_err set", frame_err, 1);
        clear_full();
        send_char(8'h11, 0, 1, -1);
        check("R8 frame_err cleared", frame_err, 0);
        clear_full();

        // R6: one-sample glitches inside data bits
        send_char(8'h0F, 0, 1, 1);
        check("R6 glitch bit0", rx_data, 8'h0F);
        clear_full();
        send_char(8'h0F, 0, 1, 6);
        check("R6 glitch bit5", rx_data, 8'h0F);
        clear_full();

        // R7: short low pulse is a false start
        rxd = 1'b0; hold_ticks(4); rxd = 1'b1;
        hold_ticks(40);
        check("R7 false start no char", rx_full, 0);
        check("R7 data unchanged", rx_data, 8'h0F);

        // R5: mid-frame the holding register is unchanged
        fork
            send_char(8'h77, 0, 1, -1);
            begin
                hold_ticks(80);
                check("R5 data held mid-frame", rx_data, 8'h0F);
                check("R5 full held mid-frame", rx_full, 0);
            end
        join
        check("R5 data after stop", rx_data, 8'h77);

        // R11: overwrite while still full
        send_char(8'h99, 0, 1, -1);
        check("R11 overwrite data", rx_data, 8'h99);
        check("R11 full stays", rx_full, 1);
        clear_full();

        // R12: slower tick rate
        tick_div = 3;
        hold_ticks(8);
        send_char(8'h6E, 0, 1, -1);
        check("R12 slow tick data", rx_data, 8'h6E);
        check("R12 slow tick full", rx_full, 1);

        finish_run();
    end
endmodule